// File: doc/BRIEF.md
# Serial TDM Time-Slot Interchange

This block moves bytes between time slots of serial TDM streams. Every frame it gathers each channel of every input stream into a data memory. It then rebuilds each output stream channel by channel. A connection memory holds one word per output stream and channel. That word either picks a stored source channel to forward, or it carries a byte of its own that goes out unchanged on that slot. Switched channels and message channels can share one output stream.

One master frame pulse and one bit clock time the whole block. The data memory has two halves. Input fills one half while output drains the other, so every switched byte appears exactly one frame after it arrived. A small synchronous host port can read and write a control register and the connection memory. It can only read the data memory, which lets it watch the most recent complete frame of input traffic. Host changes to connection words and to the control register are staged and take effect only at the next frame boundary.

Top module: `tsi_switch`

## Requirements
- R1: `fp` is high for one cycle, on the last bit of a frame; the next cycle is bit 0 of channel 0. A frame is NCH×8 cycles. Input channel c, bit position k (k=0 is the MSB) is sampled at the clock edge that ends cycle 8c+k of the frame.
- R2: A connection word with bit 8 = 0 and bit 7 = 1 makes the output channel carry the byte that arrived in the previous frame on source stream bits[6:5], source channel bits[4:0]. Output channel c, MSB first, occupies cycles 8c+1 to 8c+8 counted from the frame start, so the last bit falls in cycle 0 of the following frame.
- R3: A connection word with bit 8 = 1 sends its bits[7:0] directly as the channel byte, with `oe` high, whatever the value of bit 7.
- R4: Mode is chosen per output channel, so switched, message and disabled channels can mix within one output stream. The same source may feed several outputs.
- R5: A connection word with bits 8 and 7 both 0 leaves the channel undriven: `oe` low and `sout` high for its eight cycles.
- R6: Until the frame that starts after the second frame pulse following reset, every output channel is idle (`oe` low, `sout` high).
- R7: Host address bits[8:7] select the region: 00 control, 01 connection memory, 10 data memory. Bits[6:0] are {stream[1:0], channel[4:0]}. The read data appears on `hrdata` the cycle after a read strobe and holds otherwise. A connection word reads back as written at once, but controls the output only from the next frame boundary.
- R8: A read from the data region returns the byte received on that stream and channel in the last completed frame. Writes to that region are ignored.
- R9: Control bit 0 mutes every output (idle) from the next frame boundary while set; it reads back as written.
- R10: Reset clears all connection words and the control register to 0, drives `sout` all ones, `oe` all zeros and `hrdata` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| fp | input | 1 | Frame pulse, high on the last bit of a frame |
| sin | input | 4 | Serial input streams |
| sout | output | 4 | Serial output streams |
| oe | output | 4 | Per-stream drive enable for the current output bit |
| hsel | input | 1 | Host access strobe |
| hwr | input | 1 | Host write (1) or read (0) |
| haddr | input | 9 | Host address {region[1:0], stream[1:0], channel[4:0]} |
| hwdata | input | 16 | Host write data |
| hrdata | output | 16 | Host read data, registered |

## Verification
The bench builds the block with its defaults: four streams of 32 channels, which gives a 256-cycle frame and a two-frame start-up hold. At this size a run of fourteen frames covers every output slot under a random mix of modes. It also reaches the cross-frame case where output channel 0 takes input channel 31, whose byte is written on the same edge that the halves of the data memory swap. Host writes land at random points inside frames, so the one-frame staging of connection words and of the mute bit is tested against a reference model that takes its snapshot only at frame pulses.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] IDLE_BYTE = '1;

  typedef enum logic [1:0] {
    HR_CTRL = 2'd0,
    HR_CONN = 2'd1,
    HR_DATA = 2'd2,
    HR_NONE = 2'd3
  } host_region_e;

endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer #(
  parameter int unsigned FRAME_BITS  = 256,
  parameter int unsigned HOLD_FRAMES = 2,
  localparam int unsigned PW = $clog2(FRAME_BITS),
  localparam int unsigned HW = $clog2(HOLD_FRAMES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fp,
  output logic [PW-1:0] pos,
  output logic          wbank,
  output logic          ready
);

  logic [HW-1:0] pulses_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos         <= '0;
      wbank       <= 1'b0;
      pulses_seen <= '0;
    end else if (fp) begin
      pos   <= '0;
      wbank <= ~wbank;
      if (pulses_seen != HW'(HOLD_FRAMES)) pulses_seen <= pulses_seen + 1'b1;
    end else if (pos == PW'(FRAME_BITS - 1)) begin
      pos <= '0;
    end else begin
      pos <= pos + 1'b1;
    end
  end

  assign ready = (pulses_seen == HW'(HOLD_FRAMES));

endmodule

// File: rtl/tsi_rx_lane.sv
module tsi_rx_lane #(
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sin,
  output logic [BW-1:0] word
);

  logic [BW-2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[BW-3:0], sin};
  end

  // completed byte, valid at the edge that samples the last bit
  assign word = {sh, sin};

endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane #(
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          drive,
  input  logic [BW-1:0] word,
  output logic          sout,
  output logic          oe
);

  logic [BW-1:0] sh;
  logic          oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      oe_q <= 1'b0;
    end else if (load) begin
      sh   <= word;
      oe_q <= drive;
    end else begin
      sh <= {sh[BW-2:0], 1'b1};
    end
  end

  assign sout = sh[BW-1];
  assign oe   = oe_q;

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int unsigned NSTR        = 4,
  parameter int unsigned NCH         = 32,
  parameter int unsigned HOLD_FRAMES = 2,
  parameter int unsigned DW          = 16,
  localparam int unsigned BW         = BYTE_W,
  localparam int unsigned BIW        = $clog2(BW),
  localparam int unsigned SW         = $clog2(NSTR),
  localparam int unsigned CW         = $clog2(NCH),
  localparam int unsigned IW         = SW + CW,
  localparam int unsigned SLOTS      = NSTR * NCH,
  localparam int unsigned FRAME_BITS = NCH * BW,
  localparam int unsigned PW         = $clog2(FRAME_BITS),
  localparam int unsigned LOW_W      = (IW + 1 > BW) ? IW + 1 : BW,
  localparam int unsigned CMW        = LOW_W + 1,
  localparam int unsigned AW         = IW + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fp,
  input  logic [NSTR-1:0] sin,
  output logic [NSTR-1:0] sout,
  output logic [NSTR-1:0] oe,
  input  logic            hsel,
  input  logic            hwr,
  input  logic [AW-1:0]   haddr,
  input  logic [DW-1:0]   hwdata,
  output logic [DW-1:0]   hrdata
);

  // connection word: {message, enable, source stream, source channel}
  function automatic logic cm_is_msg(input logic [CMW-1:0] w);
    return w[CMW-1];
  endfunction

  function automatic logic cm_enabled(input logic [CMW-1:0] w);
    return w[IW];
  endfunction

  function automatic logic [IW-1:0] cm_source(input logic [CMW-1:0] w);
    return w[IW-1:0];
  endfunction

  function automatic logic [BW-1:0] cm_message(input logic [CMW-1:0] w);
    return w[BW-1:0];
  endfunction

  function automatic logic [IW-1:0] slot_of(input logic [SW-1:0] s, input logic [CW-1:0] c);
    return {s, c};
  endfunction

  // frame position and named events
  logic [PW-1:0]  pos;
  logic           wbank;
  logic           rbank;
  logic           ready;
  logic [CW-1:0]  chan;
  logic [BIW-1:0] bitn;
  logic           chan_end;
  logic           chan_start;

  tsi_frame_timer #(
    .FRAME_BITS (FRAME_BITS),
    .HOLD_FRAMES(HOLD_FRAMES)
  ) u_timer (
    .clk  (clk),
    .rst  (rst),
    .fp   (fp),
    .pos  (pos),
    .wbank(wbank),
    .ready(ready)
  );

  assign chan       = pos[PW-1:BIW];
  assign bitn       = pos[BIW-1:0];
  assign chan_end   = (bitn == BIW'(BW - 1));
  assign chan_start = (bitn == '0);
  assign rbank      = ~wbank;

  // storage
  logic [BW-1:0]  dmem    [2][SLOTS];
  logic [CMW-1:0] cm_host [SLOTS];
  logic [CMW-1:0] cm_live [SLOTS];
  logic           mute_host;
  logic           mute_live;
  logic [BW-1:0]  rx_word [NSTR];

  // input side
  for (genvar s = 0; s < NSTR; s++) begin : g_rx
    tsi_rx_lane #(.BW(BW)) u_rx (
      .clk (clk),
      .rst (rst),
      .sin (sin[s]),
      .word(rx_word[s])
    );
  end

  always_ff @(posedge clk) begin
    if (chan_end) begin
      for (int s = 0; s < NSTR; s++) dmem[wbank][slot_of(SW'(s), chan)] <= rx_word[s];
    end
  end

  // host port and frame-synchronous staging
  host_region_e  hreg;
  logic [IW-1:0] hidx;
  logic          unused_hwdata_bits;

  assign hreg               = host_region_e'(haddr[AW-1 -: 2]);
  assign hidx               = haddr[IW-1:0];
  assign unused_hwdata_bits = &{1'b0, hwdata[DW-1:CMW]};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) begin
        cm_host[i] <= '0;
        cm_live[i] <= '0;
      end
      mute_host <= 1'b0;
      mute_live <= 1'b0;
      hrdata    <= '0;
    end else begin
      if (hsel && hwr) begin
        case (hreg)
          HR_CTRL: mute_host     <= hwdata[0];
          HR_CONN: cm_host[hidx] <= hwdata[CMW-1:0];
          default: ;
        endcase
      end
      if (hsel && !hwr) begin
        case (hreg)
          HR_CTRL: hrdata <= DW'(mute_host);
          HR_CONN: hrdata <= DW'(cm_host[hidx]);
          HR_DATA: hrdata <= DW'(dmem[rbank][hidx]);
          default: hrdata <= '0;
        endcase
      end
      if (fp) begin
        cm_live   <= cm_host;
        mute_live <= mute_host;
      end
    end
  end

  // output side
  for (genvar o = 0; o < NSTR; o++) begin : g_tx
    logic [CMW-1:0] w;
    logic           drv;
    logic [BW-1:0]  word;

    assign w    = cm_live[slot_of(SW'(o), chan)];
    assign drv  = ready && !mute_live && (cm_is_msg(w) || cm_enabled(w));
    assign word = !drv          ? IDLE_BYTE :
                  cm_is_msg(w)  ? cm_message(w) :
                                  dmem[rbank][cm_source(w)];

    tsi_tx_lane #(.BW(BW)) u_tx (
      .clk  (clk),
      .rst  (rst),
      .load (chan_start),
      .drive(drv),
      .word (word),
      .sout (sout[o]),
      .oe   (oe[o])
    );
  end

endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int unsigned NSTR = 4,
  parameter int unsigned PW   = 8,
  parameter int unsigned DW   = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            fp,
  input logic [NSTR-1:0] sout,
  input logic [NSTR-1:0] oe,
  input logic            hsel,
  input logic            hwr,
  input logic [DW-1:0]   hrdata,
  input logic [PW-1:0]   pos,
  input logic            wbank,
  input logic            ready
);

  // R1: a frame pulse restarts the position count
  a_r1_frame_restart: assert property (@(posedge clk) disable iff (rst)
    fp |=> (pos == '0));

  // R2: the data memory halves swap exactly at frame pulses
  a_r2_bank_swap: assert property (@(posedge clk) disable iff (rst)
    fp |=> (wbank != $past(wbank)));

  a_r2_bank_hold: assert property (@(posedge clk) disable iff (rst)
    !fp |=> $stable(wbank));

  // R5: an undriven line always rests high
  a_r5_idle_line_high: assert property (@(posedge clk) disable iff (rst)
    (&(sout | oe)));

  // R6: nothing is driven while the start-up hold lasts
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (oe == '0));

  // R7: read data changes only after a read strobe
  a_r7_read_hold: assert property (@(posedge clk) disable iff (rst)
    !(hsel && !hwr) |=> $stable(hrdata));

endmodule

bind tsi_switch tsi_switch_chk #(
  .NSTR(NSTR),
  .PW  (PW),
  .DW  (DW)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .fp    (fp),
  .sout  (sout),
  .oe    (oe),
  .hsel  (hsel),
  .hwr   (hwr),
  .hrdata(hrdata),
  .pos   (pos),
  .wbank (wbank),
  .ready (ready)
);

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb;

  localparam int NF = 14;
  localparam int NV = 10;

  // {slot index = stream*32+channel, connection word}; expected readback is the word itself
  localparam logic [15:0] VEC [NV] = '{
    {7'd0,   9'b0_1_11_11111},  // out0 ch0 <- in3 ch31 (wrap across swap)
    {7'd1,   9'b1_1010_0101},   // out0 ch1 message A5
    {7'd2,   9'b1_0000_0000},   // out0 ch2 message 00, bit7 clear still driven
    {7'd3,   9'b0_0_01_00101},  // out0 ch3 disabled
    {7'd63,  9'b0_1_00_00000},  // out1 ch31 <- in0 ch0
    {7'd37,  9'b0_1_01_00101},  // out1 ch5 <- in1 ch5
    {7'd64,  9'b1_1111_1111},   // out2 ch0 message FF
    {7'd65,  9'b0_1_11_00000},  // out2 ch1 <- in3 ch0
    {7'd112, 9'b0_1_10_10000},  // out3 ch16 <- in2 ch16
    {7'd113, 9'b0_1_11_00000}   // out3 ch17 <- in3 ch0 (shared source)
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fp = 1'b0;
  logic [3:0]  sin = 4'hF;
  logic [3:0]  sout;
  logic [3:0]  oe;
  logic        hsel = 1'b0;
  logic        hwr = 1'b0;
  logic [8:0]  haddr = '0;
  logic [15:0] hwdata = '0;
  logic [15:0] hrdata;

  always #4 clk = ~clk;

  tsi_switch u_dut (
    .clk   (clk),
    .rst   (rst),
    .fp    (fp),
    .sin   (sin),
    .sout  (sout),
    .oe    (oe),
    .hsel  (hsel),
    .hwr   (hwr),
    .haddr (haddr),
    .hwdata(hwdata),
    .hrdata(hrdata)
  );

  int checks = 0;
  int errors = 0;
  int t = 0;
  int fr = -1;
  int fpcount = 0;
  bit go = 0;
  bit done = 0;

  logic [7:0] in_data [NF][4][32];
  logic [8:0] m_cm [128];
  bit         m_mute = 0;

  logic [7:0] exp_b  [4][32];
  logic       exp_oe [4][32];
  string      exp_tag[4][32];
  logic [7:0] prev_b  [4][32];
  logic       prev_oe [4][32];
  string      prev_tag[4][32];

  logic [7:0] got   [4];
  logic       oe0   [4];
  logic       oebad [4];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // one output bit; compare a whole channel when its eighth bit arrives
  task automatic take_bit(input bit use_prev, input int c, input int k);
    for (int o = 0; o < 4; o++) begin
      got[o] = {got[o][6:0], sout[o]};
      if (k == 0) begin
        oe0[o]   = oe[o];
        oebad[o] = 1'b0;
      end else if (oe[o] !== oe0[o]) begin
        oebad[o] = 1'b1;
      end
      if (k == 7) begin
        if (use_prev)
          check({oebad[o], oe0[o], got[o]} === {1'b0, prev_oe[o][c], prev_b[o][c]},
                $sformatf("%s out%0d ch%0d", prev_tag[o][c], o, c),
                {22'd0, oebad[o], oe0[o], got[o]}, {23'd0, prev_oe[o][c], prev_b[o][c]});
        else
          check({oebad[o], oe0[o], got[o]} === {1'b0, exp_oe[o][c], exp_b[o][c]},
                $sformatf("%s out%0d ch%0d", exp_tag[o][c], o, c),
                {22'd0, oebad[o], oe0[o], got[o]}, {23'd0, exp_oe[o][c], exp_b[o][c]});
      end
    end
  endtask

  // reference: expected channel contents of the frame about to start
  task automatic build_expect();
    prev_b   = exp_b;
    prev_oe  = exp_oe;
    prev_tag = exp_tag;
    fpcount++;
    for (int o = 0; o < 4; o++) begin
      for (int c = 0; c < 32; c++) begin
        logic [8:0] w;
        w = m_cm[o*32 + c];
        if (fpcount < 2) begin
          exp_b[o][c] = 8'hFF; exp_oe[o][c] = 1'b0; exp_tag[o][c] = "R6";
        end else if (m_mute) begin
          exp_b[o][c] = 8'hFF; exp_oe[o][c] = 1'b0; exp_tag[o][c] = "R9";
        end else if (w[8]) begin
          exp_b[o][c] = w[7:0]; exp_oe[o][c] = 1'b1; exp_tag[o][c] = "R3";
        end else if (w[7]) begin
          // R1 bit order and R4 per-channel mixing are seen through every switched byte
          exp_b[o][c] = in_data[fr][w[6:5]][w[4:0]]; exp_oe[o][c] = 1'b1; exp_tag[o][c] = "R2";
        end else begin
          exp_b[o][c] = 8'hFF; exp_oe[o][c] = 1'b0; exp_tag[o][c] = "R5";
        end
      end
    end
  endtask

  // serial engine: drives frames, checks every output channel
  initial begin : engine
    wait (go);
    t = 255;
    fr = -1;
    while (fr < NF) begin
      @(negedge clk);
      if (fr >= 0) begin
        if (t == 0) begin
          if (fr >= 1) take_bit(1'b1, 31, 7);
        end else begin
          take_bit(1'b0, (t - 1) / 8, (t - 1) % 8);
        end
      end
      fp = (t == 255);
      for (int s = 0; s < 4; s++)
        sin[s] = (fr >= 0) ? in_data[fr][s][t / 8][7 - (t % 8)] : 1'b1;
      if (t == 255) begin
        build_expect();
        t = 0;
        fr++;
      end else begin
        t++;
      end
    end
    @(negedge clk);
    fp = 1'b0;
    done = 1'b1;
  end

  task automatic wait_safe();
    do @(negedge clk); while (!(fr >= 0 && t >= 8 && t <= 200));
  endtask

  task automatic host_wr(input logic [8:0] a, input logic [15:0] d);
    wait_safe();
    hsel = 1'b1; hwr = 1'b1; haddr = a; hwdata = d;
    if (a[8:7] == 2'b01) m_cm[a[6:0]] = d[8:0];
    if (a[8:7] == 2'b00) m_mute = d[0];
    @(negedge clk);
    hsel = 1'b0; hwr = 1'b0;
  endtask

  task automatic host_rd(input logic [8:0] a, output logic [15:0] d, output int f);
    wait_safe();
    f = fr;
    hsel = 1'b1; hwr = 1'b0; haddr = a;
    @(negedge clk);
    d = hrdata;
    hsel = 1'b0;
  endtask

  task automatic wait_frame(input int n);
    while (fr < n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin : main
    logic [15:0] d;
    int f;
    for (int i = 0; i < 128; i++) m_cm[i] = '0;
    for (int f2 = 0; f2 < NF; f2++)
      for (int s = 0; s < 4; s++)
        for (int c = 0; c < 32; c++) in_data[f2][s][c] = 8'($urandom);

    repeat (5) @(negedge clk);
    // R10: reset state at the ports
    check(sout === 4'hF, "R10 sout", 32'(sout), 32'hF);
    check(oe === 4'h0, "R10 oe", 32'(oe), 32'h0);
    check(hrdata === 16'h0, "R10 hrdata", 32'(hrdata), 32'h0);
    rst = 1'b0;
    go = 1'b1;

    host_rd({2'b01, 7'd77}, d, f);
    check(d === 16'h0, "R10 connection word cleared", 32'(d), 32'h0);
    host_rd({2'b00, 7'd0}, d, f);
    check(d === 16'h0, "R10 control cleared", 32'(d), 32'h0);

    // random mix of switched, message and disabled channels (R4)
    for (int i = 0; i < 128; i++) host_wr({2'b01, 7'(i)}, {7'd0, 9'($urandom)});

    // directed connection vectors with readback (R7)
    for (int i = 0; i < NV; i++) begin
      host_wr({2'b01, VEC[i][15:9]}, {7'd0, VEC[i][8:0]});
      host_rd({2'b01, VEC[i][15:9]}, d, f);
      check(d === {7'd0, VEC[i][8:0]}, "R7 connection readback", 32'(d), {23'd0, VEC[i][8:0]});
    end

    // data memory snooping (R8)
    wait_frame(4);
    for (int i = 0; i < 4; i++) begin
      int s, c;
      s = i;
      c = (i * 9 + 31) % 32;
      host_rd({2'b10, 2'(s), 5'(c)}, d, f);
      check(d === {8'd0, in_data[f-1][s][c]}, "R8 data read", 32'(d), {24'd0, in_data[f-1][s][c]});
    end
    host_wr({2'b10, 2'd2, 5'd7}, 16'h005A);
    host_rd({2'b10, 2'd2, 5'd7}, d, f);
    check(d === {8'd0, in_data[f-1][2][7]}, "R8 data write ignored", 32'(d), {24'd0, in_data[f-1][2][7]});

    // mute control (R9)
    wait_frame(6);
    host_wr({2'b00, 7'd0}, 16'h0001);
    host_rd({2'b00, 7'd0}, d, f);
    check(d === 16'h0001, "R9 control readback", 32'(d), 32'h1);
    wait_frame(8);
    host_wr({2'b00, 7'd0}, 16'h0000);
    host_rd({2'b00, 7'd0}, d, f);
    check(d === 16'h0000, "R9 control cleared", 32'(d), 32'h0);

    // late change of a connection word lands at the next boundary (R7)
    wait_frame(10);
    host_wr({2'b01, 7'd0}, 16'h01C3);

    wait (done);
    @(negedge clk);
    summary();
    $finish;
  end

endmodule